// File: doc/BRIEF.md
# Multi-Stage Thermal Protection Evaluator

This block turns four raw sensor temperature codes into one protection temperature and compares it against three cascaded stage limits. The protection temperature comes from one of three strategies: the mean of the four codes, the hottest of the four, or one sensor picked by index. A fourth strategy code is reserved, and with it no stage can come on. A larger raw code means a hotter die.

The comparison is made once for each sample-valid strobe. Each stage keeps a registered level that shows whether the protection temperature is at or above its limit. A stage also gives a one-cycle event pulse when its level goes from off to on. The events sit at fixed bit positions of a 32-bit interrupt status word that feeds a status register further along. The third stage limit is normally the hardware shutdown temperature. The first two limits may be left at zero, and a limit of zero turns its stage off.

Top module: `tprot_top`

## Requirements
- R1: With strategy code 00 in control bits 17:16, the protection temperature is the sum of the four 15-bit codes shifted right by two (rounded down).
- R2: With strategy code 01, the protection temperature is the largest of the four codes.
- R3: With strategy code 10, the protection temperature is the code of the sensor whose index 0..3 is in control bits 19:18.
- R4: With strategy code 11 (reserved), a strobe leaves all three stage levels inactive.
- R5: On a strobe, a stage level becomes active when the protection temperature is greater than or equal to that stage's 15-bit limit, and becomes inactive otherwise.
- R6: A stage whose limit is zero is never active.
- R7: A stage event pulses high for exactly one cycle, and only when a strobe moves that stage from inactive to active. A stage that stays active gives no further events.
- R8: Without a strobe, the stage levels hold their values and no events are produced, whatever the inputs do.
- R9: The status word carries the stage 1, 2 and 3 events in bits 29, 30 and 31. All other bits are zero.
- R10: After reset all levels, events and status bits are zero.
- R11: The mean is computed without overflow: four codes of 0x7FFF give a protection temperature of 0x7FFF.
- R12: Levels and events appear on the outputs in the cycle after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Strobe: evaluate the current sensor codes |
| temp_i | input | 60 | Four 15-bit sensor codes, sensor 0 in bits 14:0 |
| ctrl_i | input | 32 | Control word: strategy in bits 17:16, sensor index in bits 19:18 |
| thr_i | input | 45 | Three 15-bit stage limits, stage 1 in bits 14:0 |
| stage_evt_o | output | 3 | One-cycle rising events, bit 0 is stage 1 |
| stage_lvl_o | output | 3 | Registered stage levels, bit 0 is stage 1 |
| irq_stat_o | output | 32 | Interrupt status word with events at bits 31:29 |

## Verification
The bench builds the block with its default parameters: 15-bit codes, four sensors and three stages. This gives the 17-bit sum that the all-maximum mean case needs. Because there are only four sensors, every index of the sensor select and every strategy code can be reached directly. Directed sequences cover the inclusive limit edge, zero limits, re-arming after a fall, and idle cycles between strobes. A random run with limits drawn close to the sensor codes is then compared every cycle with a behavioural model.

// File: rtl/tprot_pkg.sv
package tprot_pkg;
  typedef enum logic [1:0] {
    STRAT_AVG = 2'b00,
    STRAT_MAX = 2'b01,
    STRAT_SEL = 2'b10,
    STRAT_RSV = 2'b11
  } strat_e;

  localparam int unsigned CTRL_STRAT_LSB = 16;
  localparam int unsigned CTRL_SEL_LSB   = 18;
  localparam int unsigned STAT_EVT_LSB   = 29;
endpackage

// File: rtl/tprot_combiner.sv
module tprot_combiner
  import tprot_pkg::*;
#(
  parameter int unsigned TW     = 15,
  parameter int unsigned N_SENS = 4,
  localparam int unsigned LOG_N = $clog2(N_SENS),
  localparam int unsigned SEL_W = (LOG_N > 0) ? LOG_N : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SENS*TW-1:0] temp_i,
  input  strat_e               strat_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic [TW-1:0]        ptemp_o,
  output logic                 en_o
);
  localparam int unsigned SUM_W = TW + LOG_N;

  logic [TW-1:0]    t_arr [N_SENS];
  logic [SUM_W-1:0] psum  [N_SENS];
  logic [TW-1:0]    pmax  [N_SENS];
  logic [TW-1:0]    avg_t;

  for (genvar g = 0; g < N_SENS; g++) begin : g_chain
    assign t_arr[g] = temp_i[g*TW +: TW];
    if (g == 0) begin : g_first
      assign psum[g] = SUM_W'(t_arr[g]);
      assign pmax[g] = t_arr[g];
    end else begin : g_next
      assign psum[g] = psum[g-1] + SUM_W'(t_arr[g]);
      assign pmax[g] = (t_arr[g] > pmax[g-1]) ? t_arr[g] : pmax[g-1];
    end
  end

  // sum of N_SENS codes, divided by a power of two
  assign avg_t = psum[N_SENS-1][SUM_W-1 -: TW];

  always_comb begin
    en_o = 1'b1;
    unique case (strat_i)
      STRAT_AVG: ptemp_o = avg_t;
      STRAT_MAX: ptemp_o = pmax[N_SENS-1];
      STRAT_SEL: ptemp_o = t_arr[sel_i];
      default: begin
        ptemp_o = '0;
        en_o    = 1'b0;
      end
    endcase
  end

  for (genvar g = 0; g < N_SENS; g++) begin : g_chk
    assert_max_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strat_i == STRAT_MAX) |-> (ptemp_o >= t_arr[g]));
  end

  assert_avg_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strat_i == STRAT_AVG) |-> (ptemp_o <= pmax[N_SENS-1]));

  assert_rsv_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strat_i == STRAT_RSV) |-> !en_o);
endmodule

// File: rtl/tprot_stage.sv
module tprot_stage #(
  parameter int unsigned TW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          en_i,
  input  logic [TW-1:0] ptemp_i,
  input  logic [TW-1:0] thr_i,
  output logic          lvl_o,
  output logic          evt_o
);
  logic hit;

  assign hit = en_i && (thr_i != '0) && (ptemp_i >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= vld_i && hit && !lvl_o;
      if (vld_i) lvl_o <= hit;
    end
  end

  assert_evt_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (lvl_o && !$past(lvl_o)));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(lvl_o) && !evt_o));

  assert_zero_thr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && thr_i == '0) |=> !lvl_o);

  assert_inclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && en_i && thr_i != '0 && ptemp_i == thr_i) |=> lvl_o);
endmodule

// File: rtl/tprot_top.sv
module tprot_top
  import tprot_pkg::*;
#(
  parameter int unsigned TW      = 15,
  parameter int unsigned N_SENS  = 4,
  parameter int unsigned N_STAGE = 3,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned STAT_W  = 32,
  localparam int unsigned LOG_N  = $clog2(N_SENS),
  localparam int unsigned SEL_W  = (LOG_N > 0) ? LOG_N : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sample_vld_i,
  input  logic [N_SENS*TW-1:0]  temp_i,
  input  logic [CTRL_W-1:0]     ctrl_i,
  input  logic [N_STAGE*TW-1:0] thr_i,
  output logic [N_STAGE-1:0]    stage_evt_o,
  output logic [N_STAGE-1:0]    stage_lvl_o,
  output logic [STAT_W-1:0]     irq_stat_o
);
  strat_e           strat;
  logic [SEL_W-1:0] sel;
  logic [TW-1:0]    ptemp;
  logic             en;

  assign strat = strat_e'(ctrl_i[CTRL_STRAT_LSB +: 2]);
  assign sel   = ctrl_i[CTRL_SEL_LSB +: SEL_W];

  tprot_combiner #(.TW(TW), .N_SENS(N_SENS)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .temp_i  (temp_i),
    .strat_i (strat),
    .sel_i   (sel),
    .ptemp_o (ptemp),
    .en_o    (en)
  );

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    tprot_stage #(.TW(TW)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_i   (sample_vld_i),
      .en_i    (en),
      .ptemp_i (ptemp),
      .thr_i   (thr_i[s*TW +: TW]),
      .lvl_o   (stage_lvl_o[s]),
      .evt_o   (stage_evt_o[s])
    );
  end

  assign irq_stat_o = STAT_W'(stage_evt_o) << STAT_EVT_LSB;

  assert_rsv_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && strat == STRAT_RSV) |=> (stage_lvl_o == '0));

  assert_stat_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_evt_o == '0) |-> (irq_stat_o == '0));
endmodule

// File: tb/tprot_top_bench.sv
`timescale 1ns/100ps
module tprot_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [14:0] t  [4];
  logic [14:0] th [3];
  logic [1:0]  strat = 2'b00;
  logic [1:0]  sel = 2'b00;
  logic [59:0] temp_flat;
  logic [44:0] thr_flat;
  logic [31:0] ctrl;
  logic [2:0]  evt, lvl;
  logic [31:0] stat;
  logic [2:0]  exp_lvl, exp_evt;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign temp_flat = {t[3], t[2], t[1], t[0]};
  assign thr_flat  = {th[2], th[1], th[0]};
  assign ctrl      = {12'd0, sel, strat, 16'd0};

  tprot_top u_tprot_top (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .temp_i(temp_flat),
    .ctrl_i(ctrl), .thr_i(thr_flat), .stage_evt_o(evt), .stage_lvl_o(lvl),
    .irq_stat_o(stat)
  );

  function automatic int prot_temp();
    int m;
    case (strat)
      2'b00: return (int'(t[0]) + int'(t[1]) + int'(t[2]) + int'(t[3])) / 4;
      2'b01: begin
        m = 0;
        foreach (t[i]) if (int'(t[i]) > m) m = int'(t[i]);
        return m;
      end
      2'b10: return int'(t[sel]);
      default: return -1;
    endcase
  endfunction

  function automatic logic [2:0] model_hits();
    logic [2:0] h;
    int p;
    p = prot_temp();
    for (int i = 0; i < 3; i++)
      h[i] = (p >= 0) && (th[i] != 0) && (p >= int'(th[i]));
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_lvl <= '0;
      exp_evt <= '0;
    end else begin
      logic [2:0] h;
      h = model_hits();
      exp_evt <= vld ? (h & ~exp_lvl) : 3'b000;
      if (vld) exp_lvl <= h;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model (R5 R7 R8 R9 R12)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5/R8 model lvl", 32'(lvl), 32'(exp_lvl));
      check("R7/R12 model evt", 32'(evt), 32'(exp_evt));
      check("R9 model stat", stat, {exp_evt, 29'd0});
    end
  end

  task automatic set_temps(input int a, input int b, input int c, input int d);
    t[0] = 15'(a); t[1] = 15'(b); t[2] = 15'(c); t[3] = 15'(d);
  endtask

  task automatic strobe(input logic [2:0] e_lvl, input logic [2:0] e_evt, input string tag);
    @(posedge clk); #1 vld = 1'b1;
    @(posedge clk); #1 vld = 1'b0;
    @(negedge clk);
    check({tag, " lvl"}, 32'(lvl), 32'(e_lvl));
    check({tag, " evt"}, 32'(evt), 32'(e_evt));
    check({tag, " stat"}, stat, {e_evt, 29'd0});
  endtask

  initial begin
    #20000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    set_temps(0, 0, 0, 0);
    th[0] = 15'd100; th[1] = 15'd200; th[2] = 15'd300;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset lvl", 32'(lvl), 0);
    check("R10 reset evt", 32'(evt), 0);
    check("R10 reset stat", stat, 0);
    #1 rst_n = 1'b1;

    strat = 2'b00; set_temps(100, 100, 100, 103);
    strobe(3'b001, 3'b001, "R1 avg 403/4");
    strobe(3'b001, 3'b000, "R7 no repeat");
    set_temps(999, 999, 999, 999);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 idle lvl", 32'(lvl), 32'h1);
    check("R8 idle evt", 32'(evt), 0);
    strat = 2'b00; set_temps(99, 99, 99, 101);
    strobe(3'b000, 3'b000, "R1 avg rounds down");

    strat = 2'b01; set_temps(0, 0, 0, 250);
    strobe(3'b011, 3'b011, "R2 max");
    set_temps(250, 0, 0, 0);
    strobe(3'b011, 3'b000, "R2 max other sensor");

    strat = 2'b10; sel = 2'd2; set_temps(0, 0, 300, 0);
    strobe(3'b111, 3'b100, "R3 sel 2 R5 equal");
    sel = 2'd0; set_temps(299, 5, 5, 5);
    strobe(3'b011, 3'b000, "R3 sel 0 R5 below");
    sel = 2'd3; set_temps(0, 0, 0, 200);
    strobe(3'b011, 3'b000, "R3 sel 3");

    strat = 2'b11; set_temps(32767, 32767, 32767, 32767);
    strobe(3'b000, 3'b000, "R4 reserved");

    th[0] = 15'd0; th[1] = 15'd200; th[2] = 15'd32767;
    strat = 2'b01; set_temps(150, 10, 10, 10);
    strobe(3'b000, 3'b000, "R6 zero limit");
    strat = 2'b00; set_temps(32767, 32767, 32767, 32767);
    strobe(3'b110, 3'b110, "R11 full-scale mean");
    set_temps(0, 0, 0, 0);
    strobe(3'b000, 3'b000, "R5 fall");
    set_temps(32767, 32767, 32767, 32767);
    strobe(3'b110, 3'b110, "R7 re-rise");

    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      vld = ($urandom_range(0, 2) != 0);
      strat = 2'($urandom_range(0, 3));
      sel = 2'($urandom_range(0, 3));
      for (int i = 0; i < 4; i++) t[i] = 15'($urandom_range(900, 1100));
      for (int i = 0; i < 3; i++)
        th[i] = ($urandom_range(0, 7) == 0) ? 15'd0 : 15'($urandom_range(950, 1050));
    end
    @(posedge clk); #1 vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule